// File: doc/BRIEF.md
# Reloadable System Clock Prescaler

This block slows an oscillator clock down to a lower system rate. It produces a single-cycle enable strobe in the oscillator domain, not a derived clock. Downstream logic advances only on cycles where the strobe is high, so the whole design stays on one clock. The division comes from an up-counter that restarts from a software-written reload value each time it wraps. Each wrap flips an internal half-period phase, and the strobe fires on every second wrap, so the division ratio is always even.

A rate-select input sets the base step. In single-rate mode the counter advances every second oscillator cycle. In double-rate mode it advances every cycle, which halves every ratio. A reload value of all ones is a bypass code. In bypass the counter stands still and the strobe follows the base step directly. The reload register can be rewritten while the block runs. Between divided settings, a new value is picked up only at the next wrap, so the output never stalls.

Top module: `clk_prescaler`

## Requirements
- R1: With a reload value R below 0xFF and the rate input low, sys_en_o pulses once every 4*(255-R) oscillator cycles (ratios 4 to 1020).
- R2: With a reload value R below 0xFF and the rate input high, sys_en_o pulses once every 2*(255-R) cycles (ratios 2 to 510).
- R3: With reload value 0xFF (bypass), sys_en_o pulses every second cycle when the rate input is low and is high on every cycle when it is high.
- R4: Whenever the period is longer than one cycle, each pulse of sys_en_o lasts exactly one cycle.
- R5: A write between two divided settings takes effect at the next wrap. If the write is sampled in strobe cycle s, with k = 2 (rate low) or 1 (rate high), the next strobe comes at s + k*((255-old)+(255-new)), and the new period applies from then on.
- R6: Writing 0xFF in strobe cycle s while dividing gives no strobe until the next wrap, at s + k*(255-old). Bypass pulses then follow, the first at s + k*(255-old) + 1 (rate high) or + 2 (rate low).
- R7: Leaving bypass by writing R below 0xFF, sampled in cycle w, restarts the count from R. There is no strobe in cycles w+2 to w+ratio, and the first full-length strobe comes at cycle w+1+ratio.
- R8: After reset the reload register holds 0xFF, so the block starts in bypass.
- R9: After any reload write, the first strobe that begins a full period at the new rate comes no more than 1024 cycles after the write.
- R10: reload_data_i has no effect while reload_wr_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dbl_rate_i | input | 1 | 1: counter advances every cycle; 0: every second cycle |
| reload_wr_i | input | 1 | Write strobe for the reload register |
| reload_data_i | input | 8 | Reload value; 0xFF selects bypass |
| sys_en_o | output | 1 | Single-cycle system clock enable strobe |

## Verification
The reload register captures a write on the edge that ends the write cycle. From then on every result is a fixed cycle count. A change between divided settings shows at the second wrap after the write. Entering bypass shows one or two cycles after the next wrap, depending on the rate. Leaving bypass shows exactly ratio+1 cycles after the write cycle. The bench drives and samples on the falling edge and keeps a running cycle number. It records the exact cycle of every strobe and compares the gaps with offsets worked out from the formulas in R1, R2 and R5 to R7. Before taking steady-state periods, it lets three strobes pass so the mixed-length period after a write has cleared.

// File: rtl/clk_prescaler_pkg.sv
package clk_prescaler_pkg;
  typedef enum logic {
    RATE_SINGLE = 1'b0,
    RATE_DOUBLE = 1'b1
  } rate_e;
endpackage

// File: rtl/clk_prescaler_tick.sv
module clk_prescaler_tick
  import clk_prescaler_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dbl_i,
  input  logic restart_i,
  output logic tick_o
);
  rate_e rate;
  logic  ph_q;

  assign rate = dbl_i ? RATE_DOUBLE : RATE_SINGLE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ph_q <= 1'b0;
    else if (restart_i) ph_q <= 1'b0;
    else                ph_q <= ~ph_q;
  end

  assign tick_o = (rate == RATE_DOUBLE) || ph_q;

  // single rate never ticks two cycles running
  assert_tick_spacing_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !dbl_i) |=> (!tick_o || dbl_i));
endmodule

// File: rtl/clk_prescaler_reload.sv
module clk_prescaler_reload #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] data_i,
  output logic [CNT_W-1:0] value_o,
  output logic             bypass_o
);
  logic [CNT_W-1:0] value_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   value_q <= '1;
    else if (wr_i) value_q <= data_i;
  end

  assign value_o  = value_q;
  assign bypass_o = &value_q;

  assert_hold_no_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(value_o));
endmodule

// File: rtl/clk_prescaler_core.sv
module clk_prescaler_core #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             reload_byp_i,
  output logic             en_o,
  output logic             restart_o
);
  localparam logic [CNT_W-1:0] ALL1 = '1;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic             byp_q;
  logic             half_q;
  logic             wrap;

  assign wrap      = !byp_q && tick_i && (cnt_q == ALL1);
  assign restart_o = byp_q && !reload_byp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= ALL1;
      byp_q  <= 1'b1;
      half_q <= 1'b0;
    end else if (byp_q) begin
      // leave bypass at once, full period from the new value
      if (!reload_byp_i) begin
        byp_q  <= 1'b0;
        cnt_q  <= reload_i + ONE;
        half_q <= 1'b0;
      end
    end else if (wrap) begin
      if (reload_byp_i) begin
        byp_q  <= 1'b1;
        half_q <= 1'b0;
      end else begin
        // skip the reload value itself: 255-R ticks per half period
        cnt_q  <= reload_i + ONE;
        half_q <= ~half_q;
      end
    end else if (tick_i) begin
      cnt_q <= cnt_q + ONE;
    end
  end

  assign en_o = byp_q ? tick_i : (wrap && half_q);

  assert_count_up_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byp_q && tick_i && cnt_q != ALL1) |=> (cnt_q == $past(cnt_q) + ONE));

  assert_reload_on_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && !reload_byp_i) |=> (cnt_q == $past(reload_i) + ONE) && (half_q != $past(half_q)));

  assert_enter_bypass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && reload_byp_i) |=> byp_q);

  assert_no_runt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(byp_q) |-> (!en_o && !half_q));
endmodule

// File: rtl/clk_prescaler.sv
module clk_prescaler #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dbl_rate_i,
  input  logic             reload_wr_i,
  input  logic [CNT_W-1:0] reload_data_i,
  output logic             sys_en_o
);
  logic [CNT_W-1:0] reload_val;
  logic             reload_byp;
  logic             tick;
  logic             restart;

  clk_prescaler_reload #(.CNT_W(CNT_W)) u_reload (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (reload_wr_i),
    .data_i   (reload_data_i),
    .value_o  (reload_val),
    .bypass_o (reload_byp)
  );

  clk_prescaler_tick u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dbl_i     (dbl_rate_i),
    .restart_i (restart),
    .tick_o    (tick)
  );

  clk_prescaler_core #(.CNT_W(CNT_W)) u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick),
    .reload_i     (reload_val),
    .reload_byp_i (reload_byp),
    .en_o         (sys_en_o),
    .restart_o    (restart)
  );

  assert_single_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_en_o && !dbl_rate_i) |=> (!sys_en_o || dbl_rate_i));
endmodule

// File: tb/clk_prescaler_test.sv
module clk_prescaler_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       dbl = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] data = 8'h00;
  logic       en;

  int checks = 0;
  int fails  = 0;
  int cyc_no = 0;
  bit last_en = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  clk_prescaler uut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .dbl_rate_i    (dbl),
    .reload_wr_i   (wr),
    .reload_data_i (data),
    .sys_en_o      (en)
  );

  function automatic int exp_ratio(logic [7:0] r, bit d);
    if (r == 8'hFF) return d ? 1 : 2;
    return (d ? 2 : 4) * (255 - int'(r));
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    cyc_no++;
    last_en = en;
    wr = 1'b0;
  endtask

  task automatic wr_reload(logic [7:0] v);
    wr = 1'b1;
    data = v;
  endtask

  task automatic next_strobe(output int at);
    at = -1;
    for (int i = 0; i < 2100; i++) begin
      cyc();
      if (last_en) begin
        at = cyc_no;
        break;
      end
    end
  endtask

  task automatic settle_measure(logic [7:0] r, bit d, string req);
    int a, b, c, x;
    int exp;
    exp = exp_ratio(r, d);
    dbl = d;
    wr_reload(r);
    next_strobe(x);
    next_strobe(x);
    next_strobe(a);
    next_strobe(b);
    next_strobe(c);
    chk((b - a) == exp, req, b - a, exp);
    chk((c - b) == exp, req, c - b, exp);
    cyc();
    if (exp > 1) chk(!last_en, "R4", int'(last_en), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int s, t, u, w, spur;
    logic [7:0] r;
    bit d;
    void'($urandom(32'd2417));

    repeat (3) cyc();
    rst_ni = 1'b1;

    // R8 / R3: bypass after reset, single rate
    next_strobe(s);
    next_strobe(t);
    next_strobe(u);
    chk((t - s) == 2, "R8", t - s, 2);
    chk((u - t) == 2, "R3", u - t, 2);

    // R3: double-rate bypass is high every cycle
    dbl = 1'b1;
    for (int i = 0; i < 6; i++) begin
      cyc();
      chk(last_en, "R3", int'(last_en), 1);
    end

    // R7: leave bypass, single rate, ratio 60
    dbl = 1'b0;
    cyc();
    w = cyc_no;
    wr_reload(8'hF0);
    spur = 0;
    while (cyc_no < w + 61) begin
      cyc();
      if (cyc_no >= w + 2 && cyc_no <= w + 60 && last_en) spur++;
    end
    chk(spur == 0, "R7", spur, 0);
    chk(last_en, "R7", int'(last_en), 1);

    // R5: change 0xF0 -> 0xE0 at a strobe
    next_strobe(s);
    chk((s - cyc_no) == 0 && (s - (w + 61)) == 60, "R1", s - (w + 61), 60);
    wr_reload(8'hE0);
    next_strobe(t);
    chk((t - s) == 92, "R5", t - s, 92);
    next_strobe(u);
    chk((u - t) == 124, "R5", u - t, 124);

    // R9: longest change 0x00 -> 0x01, single rate
    settle_measure(8'h00, 1'b0, "R1");
    next_strobe(s);
    wr_reload(8'h01);
    next_strobe(t);
    chk((t - s) == 1018, "R5", t - s, 1018);
    chk((t - s) <= 1024, "R9", t - s, 1024);

    // R6: enter bypass, single rate
    settle_measure(8'hF0, 1'b0, "R1");
    next_strobe(s);
    wr_reload(8'hFF);
    next_strobe(t);
    chk((t - s) == 32, "R6", t - s, 32);
    next_strobe(u);
    chk((u - t) == 2, "R6", u - t, 2);

    // R6: enter bypass, double rate
    settle_measure(8'hF8, 1'b1, "R2");
    next_strobe(s);
    wr_reload(8'hFF);
    next_strobe(t);
    chk((t - s) == 8, "R6", t - s, 8);
    for (int i = 0; i < 4; i++) begin
      cyc();
      chk(last_en, "R3", int'(last_en), 1);
    end

    // R2 smallest ratio
    settle_measure(8'hFE, 1'b1, "R2");

    // R10: data moves without a write strobe
    settle_measure(8'hF0, 1'b0, "R1");
    next_strobe(s);
    spur = 0;
    for (int i = 0; i < 180; i++) begin
      data = 8'($urandom_range(0, 254));
      cyc();
      if (last_en) spur++;
    end
    chk(spur == 3 && last_en, "R10", spur, 3);

    // random settings
    for (int n = 0; n < 14; n++) begin
      r = 8'($urandom_range(0, 255));
      if (n % 5 == 4) r = 8'hFF;
      d = 1'($urandom_range(0, 1));
      if (r == 8'hFF)  settle_measure(r, d, "R3");
      else if (d)      settle_measure(r, d, "R2");
      else             settle_measure(r, d, "R1");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule